// File: doc/BRIEF.md
# Memory-Board Lock Table for Split Read-Modify-Write

This controller sits on a memory board and serves atomic operations while the system bus is free between phases. A split read-modify-write begins with a locking read. The board returns the current word and records the address and the requester in a small associative table. The bus is then released. Until the same requester sends the matching locking write, any access to that word from another requester is turned away with a retry code and does not touch the array. The locking write stores the new word and frees the table slot.

The board also offers a one-shot swap. The requester sends an address and a new word in a single request. The board hands back the word it held before and stores the new one, with no table slot used. The array is held inside the block.

Each request is accepted in one cycle. Its response appears on the next cycle.

Top module: `rmw_lock_ctrl`

## Requirements
- R1: Each request with `req_valid` high at a rising edge produces exactly one response: `rsp_valid` is high during the following cycle. With no request, `rsp_valid` stays low in the next cycle.
- R2: Operation codes are 0 plain read, 1 plain write, 2 locking read, 3 locking write, 4 swap. Codes 5 to 7 get response code 2 (error). Response codes are 0 OK, 1 retry, 2 error. `rsp_rdata` carries the stored word only on an OK plain read, locking read or swap, and is zero in every other response.
- R3: A plain read or plain write to a word that is unlocked, or that is locked by the same requester, responds OK. The read returns the stored word and the write replaces it.
- R4: A plain read, plain write or locking read from a requester to a word locked by a different requester responds retry. It leaves the array and the lock table unchanged.
- R5: A locking read to an unlocked word, with a free slot available, responds OK with the stored word and locks the word for that requester. A locking read by the owner of an existing lock responds OK and takes no second slot.
- R6: A locking read to an unlocked word while all `ENTRIES` slots are in use responds retry.
- R7: A locking write whose address and requester match a held lock stores the new word, frees that lock and responds OK. Any other locking write responds error and stores nothing.
- R8: A swap to an unlocked word responds OK with the previous word, and the new word is stored by the same request. A swap to a locked word responds retry and stores nothing, whoever owns the lock.
- R9: Reset clears every lock and holds `rsp_valid` low. The array contents survive reset.
- R10: Locks on different words are independent: freeing one lock leaves the others in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_op | input | 3 | Operation code (see R2) |
| req_addr | input | AW | Word address |
| req_id | input | IW | Requester identity |
| req_wdata | input | DW | Word to store for write, locking write or swap |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | 0 OK, 1 retry, 2 error |
| rsp_rdata | output | DW | Returned word, zero unless the response is OK and returns data |

## Verification
The bench checks three cases a faulty design could get wrong:
- **Foreign write while locked.** The owner then reads the word back. A design that let the refused write through would return the foreign data.
- **Owner takes the same lock twice, then frees it once.** A design that took a second slot would leave the word locked, and a foreign read would get retry instead of OK.
- **Full table.** A fifth lock is requested while four are held. The bench then frees one lock and checks that the others stay in force, which catches any mix-up in slot selection or release.

Swaps to words locked by another requester and by the owner itself must both be refused. A locking write with the wrong requester or to an unlocked word must leave the stored word untouched.

// File: rtl/rmw_lock_pkg.sv
package rmw_lock_pkg;

   typedef enum logic [2:0] {
      OP_READ    = 3'd0,
      OP_WRITE   = 3'd1,
      OP_LOCK_RD = 3'd2,
      OP_LOCK_WR = 3'd3,
      OP_SWAP    = 3'd4
   } op_e;

   typedef enum logic [1:0] {
      RSP_OK    = 2'd0,
      RSP_RETRY = 2'd1,
      RSP_ERR   = 2'd2
   } rsp_e;

   // Outcome of one request, produced combinationally by the decider
   typedef struct packed {
      rsp_e code;
      logic give_data;
      logic mem_rd;
      logic mem_wr;
      logic take_slot;
      logic drop_slot;
   } verdict_t;

endpackage

// File: rtl/rmw_lock_cam.sv
module rmw_lock_cam #(
   parameter int unsigned ENTRIES   = 4,
   parameter int unsigned AW        = 6,
   parameter int unsigned IW        = 4,
   parameter bit          LOW_FIRST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [AW-1:0]      look_addr,
   input  logic [IW-1:0]      look_id,
   input  logic               take_en,
   input  logic               drop_en,
   output logic               hit,
   output logic               hit_own,
   output logic               full,
   output logic [ENTRIES-1:0] slot_vld
);

   logic [ENTRIES-1:0] vld;
   logic [AW-1:0]      tag   [ENTRIES];
   logic [IW-1:0]      owner [ENTRIES];
   logic [ENTRIES-1:0] match;
   logic [ENTRIES-1:0] own_match;
   logic [ENTRIES-1:0] pick;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign match[e]     = vld[e] && (tag[e] == look_addr);
      assign own_match[e] = match[e] && (owner[e] == look_id);
   end

   // Slot chosen for a new lock: the parameter picks the search direction
   if (LOW_FIRST) begin : g_pick_low
      always_comb begin
         logic found;
         found = 1'b0;
         pick  = '0;
         for (int e = 0; e < ENTRIES; e++) begin
            if (!vld[e] && !found) begin
               pick[e] = 1'b1;
               found   = 1'b1;
            end
         end
      end
   end else begin : g_pick_high
      always_comb begin
         logic found;
         found = 1'b0;
         pick  = '0;
         for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (!vld[e] && !found) begin
               pick[e] = 1'b1;
               found   = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld <= '0;
         for (int e = 0; e < ENTRIES; e++) begin
            tag[e]   <= '0;
            owner[e] <= '0;
         end
      end else begin
         for (int e = 0; e < ENTRIES; e++) begin
            if (take_en && pick[e]) begin
               vld[e]   <= 1'b1;
               tag[e]   <= look_addr;
               owner[e] <= look_id;
            end else if (drop_en && own_match[e]) begin
               vld[e] <= 1'b0;
            end
         end
      end
   end

   assign hit      = |match;
   assign hit_own  = |own_match;
   assign full     = &vld;
   assign slot_vld = vld;

endmodule

// File: rtl/rmw_lock_decide.sv
module rmw_lock_decide
   import rmw_lock_pkg::*;
(
   input  logic       req_valid,
   input  logic [2:0] req_op,
   input  logic       hit,
   input  logic       hit_own,
   input  logic       full,
   output verdict_t   verdict
);

   logic foreign;
   assign foreign = hit && !hit_own;

   always_comb begin
      verdict = '{code: RSP_OK, give_data: 1'b0, mem_rd: 1'b0,
                  mem_wr: 1'b0, take_slot: 1'b0, drop_slot: 1'b0};
      if (req_valid) begin
         case (req_op)
            OP_READ: begin
               if (foreign) verdict.code = RSP_RETRY;
               else begin
                  verdict.mem_rd    = 1'b1;
                  verdict.give_data = 1'b1;
               end
            end
            OP_WRITE: begin
               if (foreign) verdict.code = RSP_RETRY;
               else verdict.mem_wr = 1'b1;
            end
            OP_LOCK_RD: begin
               if (foreign || (!hit && full)) verdict.code = RSP_RETRY;
               else begin
                  verdict.mem_rd    = 1'b1;
                  verdict.give_data = 1'b1;
                  verdict.take_slot = !hit;
               end
            end
            OP_LOCK_WR: begin
               if (hit_own) begin
                  verdict.mem_wr    = 1'b1;
                  verdict.drop_slot = 1'b1;
               end else verdict.code = RSP_ERR;
            end
            OP_SWAP: begin
               if (hit) verdict.code = RSP_RETRY;
               else begin
                  verdict.mem_rd    = 1'b1;
                  verdict.mem_wr    = 1'b1;
                  verdict.give_data = 1'b1;
               end
            end
            default: verdict.code = RSP_ERR;
         endcase
      end
   end

endmodule

// File: rtl/rmw_lock_mem.sv
module rmw_lock_mem #(
   parameter int unsigned AW = 6,
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          rd_en,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);

   localparam int unsigned DEPTH = 1 << AW;

   logic [DW-1:0] cells [DEPTH];

   // Read-before-write: a swap sees the old word in the same cycle
   always_ff @(posedge clk) begin
      if (rd_en) rdata <= cells[addr];
      if (wr_en) cells[addr] <= wdata;
   end

endmodule

// File: rtl/rmw_lock_ctrl.sv
module rmw_lock_ctrl
   import rmw_lock_pkg::*;
#(
   parameter int unsigned ENTRIES   = 4,
   parameter int unsigned AW        = 6,
   parameter int unsigned IW        = 4,
   parameter int unsigned DW        = 16,
   parameter bit          LOW_FIRST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [2:0]    req_op,
   input  logic [AW-1:0] req_addr,
   input  logic [IW-1:0] req_id,
   input  logic [DW-1:0] req_wdata,
   output logic          rsp_valid,
   output logic [1:0]    rsp_code,
   output logic [DW-1:0] rsp_rdata
);

   if (ENTRIES < 1 || ENTRIES > 64) begin : g_bad_entries
      $error("rmw_lock_ctrl: ENTRIES must be 1..64");
   end
   if (AW < 1 || AW > 12) begin : g_bad_aw
      $error("rmw_lock_ctrl: AW must be 1..12");
   end
   if (IW < 1) begin : g_bad_iw
      $error("rmw_lock_ctrl: IW must be at least 1");
   end
   if (DW < 1) begin : g_bad_dw
      $error("rmw_lock_ctrl: DW must be at least 1");
   end

   logic               hit, hit_own, full;
   logic [ENTRIES-1:0] lock_vld;
   verdict_t           verdict;
   logic [DW-1:0]      mem_rdata;
   logic               rsp_valid_q;
   rsp_e               rsp_code_q;
   logic               give_q;

   rmw_lock_cam #(
      .ENTRIES  (ENTRIES),
      .AW       (AW),
      .IW       (IW),
      .LOW_FIRST(LOW_FIRST)
   ) u_cam (
      .clk      (clk),
      .rst_n    (rst_n),
      .look_addr(req_addr),
      .look_id  (req_id),
      .take_en  (verdict.take_slot),
      .drop_en  (verdict.drop_slot),
      .hit      (hit),
      .hit_own  (hit_own),
      .full     (full),
      .slot_vld (lock_vld)
   );

   rmw_lock_decide u_decide (
      .req_valid(req_valid),
      .req_op   (req_op),
      .hit      (hit),
      .hit_own  (hit_own),
      .full     (full),
      .verdict  (verdict)
   );

   rmw_lock_mem #(
      .AW(AW),
      .DW(DW)
   ) u_mem (
      .clk  (clk),
      .rd_en(verdict.mem_rd),
      .wr_en(verdict.mem_wr),
      .addr (req_addr),
      .wdata(req_wdata),
      .rdata(mem_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid_q <= 1'b0;
         rsp_code_q  <= RSP_OK;
         give_q      <= 1'b0;
      end else begin
         rsp_valid_q <= req_valid;
         rsp_code_q  <= verdict.code;
         give_q      <= verdict.give_data;
      end
   end

   assign rsp_valid = rsp_valid_q;
   assign rsp_code  = rsp_code_q;
   assign rsp_rdata = give_q ? mem_rdata : '0;

endmodule

// File: rtl/rmw_lock_ctrl_chk.sv
module rmw_lock_ctrl_chk
   import rmw_lock_pkg::*;
#(
   parameter int unsigned ENTRIES = 4,
   parameter int unsigned DW      = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic [2:0]         req_op,
   input logic               rsp_valid,
   input logic [1:0]         rsp_code,
   input logic [DW-1:0]      rsp_rdata,
   input logic [ENTRIES-1:0] lock_vld
);

   AST_ONE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid) else $error("request without response"); // R1
   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid) else $error("response without request"); // R1
   AST_NONOK_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_code != RSP_OK) |-> (rsp_rdata == '0)) else $error("data on non-OK"); // R2
   AST_BAD_OP_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(req_op) > 3'd4) |-> (rsp_code == RSP_ERR)) else $error("bad op not error"); // R2
   AST_RETRY_KEEPS_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_code == RSP_RETRY) |-> (lock_vld == $past(lock_vld))) else $error("retry changed locks"); // R4
   AST_UNLOCK_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_code == RSP_OK && $past(req_op) == OP_LOCK_WR)
      |-> ($countones(lock_vld) == $countones($past(lock_vld)) - 1)) else $error("unlock count"); // R7
   AST_SWAP_KEEPS_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(req_op) == OP_SWAP) |-> (lock_vld == $past(lock_vld))) else $error("swap touched locks"); // R8

endmodule

bind rmw_lock_ctrl rmw_lock_ctrl_chk #(
   .ENTRIES(ENTRIES),
   .DW     (DW)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .req_op   (req_op),
   .rsp_valid(rsp_valid),
   .rsp_code (rsp_code),
   .rsp_rdata(rsp_rdata),
   .lock_vld (lock_vld)
);

// File: tb/rmw_lock_ctrl_tb.sv
`timescale 1ns/1ps
module rmw_lock_ctrl_tb;

   localparam logic [2:0] RD = 3'd0, WR = 3'd1, LRD = 3'd2, LWR = 3'd3, SWP = 3'd4;
   localparam logic [1:0] OK = 2'd0, RETRY = 2'd1, ERR = 2'd2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_op = '0;
   logic [5:0]  req_addr = '0;
   logic [3:0]  req_id = '0;
   logic [15:0] req_wdata = '0;
   logic        rsp_valid;
   logic [1:0]  rsp_code;
   logic [15:0] rsp_rdata;

   int tests = 0;
   int fails = 0;

   always #5 clk = ~clk;

   rmw_lock_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_id(req_id), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_rdata(rsp_rdata)
   );

   // Drive one request at a falling edge, check its response one cycle later
   task automatic xact(input logic [2:0] op, input logic [5:0] a, input logic [3:0] id,
                       input logic [15:0] wd, input logic [1:0] ecode,
                       input logic [15:0] edata, input string tag);
      req_valid = 1'b1; req_op = op; req_addr = a; req_id = id; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      tests++;
      if (rsp_valid !== 1'b1 || rsp_code !== ecode || rsp_rdata !== edata) begin
         fails++;
         $display("FAIL %s: got valid=%0b code=%0d data=%h, expected valid=1 code=%0d data=%h",
                  tag, rsp_valid, rsp_code, rsp_rdata, ecode, edata);
      end
   endtask

   task automatic expect_idle(input string tag);
      tests++;
      if (rsp_valid !== 1'b0) begin
         fails++;
         $display("FAIL %s: got rsp_valid=%0b, expected 0", tag, rsp_valid);
      end
   endtask

   task automatic t_reset_state;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      expect_idle("R9 reset holds rsp_valid low");
      rst_n = 1'b1;
      @(negedge clk);
      expect_idle("R1 no response without request");
   endtask

   task automatic t_plain;
      xact(WR, 6'd5, 4'd1, 16'h1111, OK, 16'h0000, "R3 plain write");
      xact(RD, 6'd5, 4'd2, 16'h0, OK, 16'h1111, "R3 plain read");
      xact(WR, 6'd6, 4'd2, 16'h2222, OK, 16'h0000, "R3 second write");
      xact(RD, 6'd6, 4'd1, 16'h0, OK, 16'h2222, "R3 second read");
      @(negedge clk);
      expect_idle("R1 idle after traffic");
   endtask

   task automatic t_foreign;
      xact(LRD, 6'd5, 4'd1, 16'h0, OK, 16'h1111, "R5 lock read");
      xact(RD, 6'd5, 4'd2, 16'h0, RETRY, 16'h0, "R4 foreign read");
      xact(WR, 6'd5, 4'd2, 16'h9999, RETRY, 16'h0, "R4 foreign write");
      xact(LRD, 6'd5, 4'd2, 16'h0, RETRY, 16'h0, "R4 foreign lock read");
      xact(RD, 6'd5, 4'd1, 16'h0, OK, 16'h1111, "R4 foreign write not stored / R3 owner read");
      xact(LRD, 6'd5, 4'd1, 16'h0, OK, 16'h1111, "R5 owner relock");
      xact(LWR, 6'd5, 4'd1, 16'hAAAA, OK, 16'h0, "R7 matching lock write");
      xact(RD, 6'd5, 4'd2, 16'h0, OK, 16'hAAAA, "R5 single slot freed / R7 stored");
   endtask

   task automatic t_mismatch;
      xact(LRD, 6'd6, 4'd3, 16'h0, OK, 16'h2222, "R5 lock 6");
      xact(LWR, 6'd6, 4'd4, 16'hBBBB, ERR, 16'h0, "R7 wrong requester");
      xact(LWR, 6'd7, 4'd3, 16'hCCCC, ERR, 16'h0, "R7 unlocked address");
      xact(RD, 6'd6, 4'd3, 16'h0, OK, 16'h2222, "R7 nothing stored");
      xact(LWR, 6'd6, 4'd3, 16'hDDDD, OK, 16'h0, "R7 good unlock");
      xact(LWR, 6'd6, 4'd3, 16'hEEEE, ERR, 16'h0, "R7 second unlock refused");
      xact(RD, 6'd6, 4'd4, 16'h0, OK, 16'hDDDD, "R7 final word");
   endtask

   task automatic t_full;
      for (int i = 0; i < 5; i++)
         xact(WR, 6'(10 + i), 4'd0, 16'(16'h0010 + i), OK, 16'h0, "R3 prefill");
      for (int i = 0; i < 4; i++)
         xact(LRD, 6'(10 + i), 4'(1 + i), 16'h0, OK, 16'(16'h0010 + i), "R5 fill table");
      xact(LRD, 6'd14, 4'd5, 16'h0, RETRY, 16'h0, "R6 table full");
      xact(RD, 6'd14, 4'd5, 16'h0, OK, 16'h0014, "R6 word 14 not locked");
      xact(LWR, 6'd11, 4'd2, 16'h0B11, OK, 16'h0, "R7 free slot of 11");
      xact(LRD, 6'd14, 4'd5, 16'h0, OK, 16'h0014, "R6 slot reused");
      xact(RD, 6'd10, 4'd6, 16'h0, RETRY, 16'h0, "R10 lock 10 kept");
      xact(RD, 6'd12, 4'd6, 16'h0, RETRY, 16'h0, "R10 lock 12 kept");
      xact(RD, 6'd13, 4'd6, 16'h0, RETRY, 16'h0, "R10 lock 13 kept");
      xact(RD, 6'd11, 4'd6, 16'h0, OK, 16'h0B11, "R10 word 11 free");
      xact(LWR, 6'd10, 4'd1, 16'h0A10, OK, 16'h0, "R7 cleanup 10");
      xact(LWR, 6'd12, 4'd3, 16'h0A12, OK, 16'h0, "R7 cleanup 12");
      xact(LWR, 6'd13, 4'd4, 16'h0A13, OK, 16'h0, "R7 cleanup 13");
      xact(LWR, 6'd14, 4'd5, 16'h0A14, OK, 16'h0, "R7 cleanup 14");
   endtask

   task automatic t_swap;
      xact(WR, 6'd20, 4'd1, 16'h1234, OK, 16'h0, "R3 prefill 20");
      xact(SWP, 6'd20, 4'd1, 16'h5678, OK, 16'h1234, "R8 swap returns old");
      xact(RD, 6'd20, 4'd3, 16'h0, OK, 16'h5678, "R8 swap stored new");
      xact(SWP, 6'd20, 4'd3, 16'h0F0F, OK, 16'h5678, "R8 back-to-back swap");
      xact(LRD, 6'd20, 4'd2, 16'h0, OK, 16'h0F0F, "R5 lock 20");
      xact(SWP, 6'd20, 4'd3, 16'h9ABC, RETRY, 16'h0, "R8 foreign swap refused");
      xact(SWP, 6'd20, 4'd2, 16'h9ABC, RETRY, 16'h0, "R8 owner swap refused");
      xact(LWR, 6'd20, 4'd2, 16'h1111, OK, 16'h0, "R7 unlock 20");
      xact(RD, 6'd20, 4'd3, 16'h0, OK, 16'h1111, "R8 refused swaps stored nothing");
   endtask

   task automatic t_bad_op;
      xact(3'd5, 6'd20, 4'd1, 16'hFFFF, ERR, 16'h0, "R2 op 5");
      xact(3'd6, 6'd20, 4'd1, 16'hFFFF, ERR, 16'h0, "R2 op 6");
      xact(3'd7, 6'd20, 4'd1, 16'hFFFF, ERR, 16'h0, "R2 op 7");
      xact(RD, 6'd20, 4'd1, 16'h0, OK, 16'h1111, "R2 bad ops stored nothing");
   endtask

   task automatic t_reset_clears;
      xact(WR, 6'd30, 4'd1, 16'h3030, OK, 16'h0, "R3 prefill 30");
      xact(LRD, 6'd30, 4'd1, 16'h0, OK, 16'h3030, "R5 lock 30");
      xact(RD, 6'd30, 4'd2, 16'h0, RETRY, 16'h0, "R4 30 locked");
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      expect_idle("R9 rsp low in reset");
      rst_n = 1'b1;
      xact(RD, 6'd30, 4'd2, 16'h0, OK, 16'h3030, "R9 lock cleared, data kept");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset_state();
      t_plain();
      t_foreign();
      t_mismatch();
      t_full();
      t_swap();
      t_bad_op();
      t_reset_clears();
      @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule